// File: doc/BRIEF.md
# Decode-Stage Direct Branch Redirect Checker

This block sits beside the decode stage and looks at a group of up to `SLOTS` instructions in each cycle. For every valid slot that holds a branch that is both direct and unconditional, it computes the real target as the slot's PC plus its sign-extended immediate offset. It then compares that target with the next PC that fetch predicted. A slot where the two differ is a mispredict. The lowest-numbered mispredicting slot, which is the oldest in the group, produces one redirect record for fetch.

The redirect record holds the following fields:
- the corrected next PC;
- the next-next PC, which is the corrected next PC plus the 4-byte instruction size;
- a taken bit;
- the sequence number of the mispredicting instruction, used as the done point;
- a squash flag and a mispredict flag.

Together with the redirect, the block returns a per-slot kill mask and a per-slot forward mask. The kill mask marks slots younger by sequence number than the mispredicting one. The forward mask shows which slots continue to the next stage. Forward slots whose instruction reads no source operands are also flagged ready to issue.

All outputs are registered. Each result appears one clock after its group is presented and lasts for exactly that one cycle.

Top module: `early_redirect_check`

## Requirements
- R1: Only a slot whose direct and unconditional flags are both 1 is checked. A slot missing either flag never causes a redirect, even when its computed target differs from its predicted next PC.
- R2: A checked slot mispredicts when PC + sign-extended offset differs from its predicted next PC. When the two are equal, no redirect is produced.
- R3: On a redirect, the next PC equals the computed target and the next-next PC equals the target plus 4. The done sequence number equals the mispredicting slot's sequence number, and the squash and mispredict flags are both 1.
- R4: The taken bit of a redirect is 1 exactly when the mispredicting slot's actual next PC differs from its PC plus 4.
- R5: When a redirect is produced, kill mask bit i is 1 exactly when slot i is valid and its sequence number (unsigned) is greater than the done sequence number. Without a redirect, the kill mask is all zero.
- R6: Forward mask bit i is 1 when slot i is valid, not killed, and no mispredicting slot lies at a lower index than i. The mispredicting slot itself is forwarded.
- R7: Ready mask bit i is 1 exactly when forward bit i is 1 and the slot's no-source input is 1.
- R8: When several slots mispredict in one group, only the lowest-indexed one (slot 0 is oldest) defines the redirect.
- R9: Results appear on the outputs on the clock edge after the group is sampled and last for one cycle. Synchronous reset clears every output to zero.
- R10: Slots whose valid bit is 0 do not redirect, are not forwarded and are not killed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | SLOTS | Slot holds an instruction |
| in_pc | input | SLOTS*AW | Per-slot PC |
| in_pred_npc | input | SLOTS*AW | Per-slot predicted next PC |
| in_act_npc | input | SLOTS*AW | Per-slot actual next PC, used for the taken bit |
| in_direct | input | SLOTS | Branch target is encoded in the instruction |
| in_uncond | input | SLOTS | Branch is unconditional |
| in_offset | input | SLOTS*OW | Per-slot signed immediate offset |
| in_seq | input | SLOTS*SW | Per-slot sequence number |
| in_no_src | input | SLOTS | Instruction reads no source operands |
| fwd_valid | output | SLOTS | Slot forwarded to the next stage |
| fwd_ready | output | SLOTS | Forwarded slot may issue at once |
| kill_mask | output | SLOTS | Slot squashed as younger than the mispredict |
| rd_valid | output | 1 | Redirect record valid |
| rd_squash | output | 1 | Squash request to fetch |
| rd_mispred | output | 1 | Mispredict indication |
| rd_taken | output | 1 | Branch taken bit |
| rd_npc | output | AW | Corrected next PC |
| rd_nnpc | output | AW | Corrected next-next PC |
| rd_done_seq | output | SW | Sequence number of the mispredicting instruction |

## Verification
The checker is driven with groups that contain no branches and with correctly predicted direct jumps; both must stay silent. It is also driven with branches that carry only one of the two qualifying flags, which separates the qualification test from the target comparison. Mispredicts are placed in the middle slot, in slot 0, and in two slots at once to confirm that the oldest slot wins. Negative offsets exercise sign extension, and actual next PCs both equal to and different from PC+4 exercise the taken bit. Separate groups use out-of-order sequence numbers, invalid mispredicting slots and mixed no-source flags, so that the kill rule (by sequence number) is told apart from the forward cut-off (by slot position). A long run of pseudo-random groups then follows.

// File: rtl/erc_pkg.sv
package erc_pkg;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_SEQ_W  = 16;
  localparam int unsigned DEF_OFF_W  = 16;
  localparam int unsigned DEF_SLOTS  = 4;
endpackage

// File: rtl/erc_slot_eval.sv
module erc_slot_eval #(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 16
) (
  input  logic          valid,
  input  logic          direct,
  input  logic          uncond,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] pred_npc,
  input  logic [AW-1:0] act_npc,
  input  logic [OW-1:0] offset,
  output logic [AW-1:0] target,
  output logic          mis,
  output logic          taken
);
  localparam logic [AW-1:0] STEP = AW'(erc_pkg::INSN_BYTES);

  logic [AW-1:0] off_ext;
  logic          checked;

  assign off_ext = {{(AW-OW){offset[OW-1]}}, offset};
  assign target  = pc + off_ext;
  assign checked = valid & direct & uncond;
  assign mis     = checked & (target != pred_npc);
  assign taken   = act_npc != (pc + STEP);
endmodule

// File: rtl/erc_pick_oldest.sv
module erc_pick_oldest #(
  parameter int unsigned SLOTS = 4
) (
  input  logic [SLOTS-1:0] mis,
  output logic [SLOTS-1:0] first_oh,
  output logic             any
);
  always_comb begin
    logic seen;
    seen     = 1'b0;
    first_oh = '0;
    for (int i = 0; i < SLOTS; i++) begin
      first_oh[i] = mis[i] & ~seen;
      seen        = seen | mis[i];
    end
  end
  assign any = |mis;

  // R8: at most one slot is chosen as the redirect source
  always_comb begin
    if (!$isunknown(mis)) begin
      a_r8_single_winner: assert ($onehot0(first_oh) && (any == (first_oh != '0)));
    end
  end
endmodule

// File: rtl/erc_kill_gen.sv
module erc_kill_gen #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned SW    = 16
) (
  input  logic [SLOTS-1:0]    valid,
  input  logic [SLOTS*SW-1:0] seq,
  input  logic [SW-1:0]       done_seq,
  input  logic                any,
  input  logic [SLOTS-1:0]    first_oh,
  output logic [SLOTS-1:0]    kill,
  output logic [SLOTS-1:0]    fwd
);
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      kill[i] = any & valid[i] & (seq[i*SW +: SW] > done_seq);
      fwd[i]  = valid[i] & ~kill[i] & ~blocked;
      blocked = blocked | first_oh[i];
    end
  end
endmodule

// File: rtl/early_redirect_check.sv
module early_redirect_check #(
  parameter int unsigned SLOTS = erc_pkg::DEF_SLOTS,
  parameter int unsigned AW    = erc_pkg::DEF_ADDR_W,
  parameter int unsigned SW    = erc_pkg::DEF_SEQ_W,
  parameter int unsigned OW    = erc_pkg::DEF_OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLOTS-1:0]    in_valid,
  input  logic [SLOTS*AW-1:0] in_pc,
  input  logic [SLOTS*AW-1:0] in_pred_npc,
  input  logic [SLOTS*AW-1:0] in_act_npc,
  input  logic [SLOTS-1:0]    in_direct,
  input  logic [SLOTS-1:0]    in_uncond,
  input  logic [SLOTS*OW-1:0] in_offset,
  input  logic [SLOTS*SW-1:0] in_seq,
  input  logic [SLOTS-1:0]    in_no_src,
  output logic [SLOTS-1:0]    fwd_valid,
  output logic [SLOTS-1:0]    fwd_ready,
  output logic [SLOTS-1:0]    kill_mask,
  output logic                rd_valid,
  output logic                rd_squash,
  output logic                rd_mispred,
  output logic                rd_taken,
  output logic [AW-1:0]       rd_npc,
  output logic [AW-1:0]       rd_nnpc,
  output logic [SW-1:0]       rd_done_seq
);
  localparam logic [AW-1:0] STEP = AW'(erc_pkg::INSN_BYTES);

  logic [SLOTS*AW-1:0] tgt_vec;
  logic [SLOTS-1:0]    mis_vec;
  logic [SLOTS-1:0]    taken_vec;
  logic [SLOTS-1:0]    first_oh;
  logic                any_mis;
  logic [AW-1:0]       sel_tgt;
  logic [SW-1:0]       sel_seq;
  logic                sel_taken;
  logic [SLOTS-1:0]    kill_c;
  logic [SLOTS-1:0]    fwd_c;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    erc_slot_eval #(.AW(AW), .OW(OW)) u_eval (
      .valid    (in_valid[g]),
      .direct   (in_direct[g]),
      .uncond   (in_uncond[g]),
      .pc       (in_pc[g*AW +: AW]),
      .pred_npc (in_pred_npc[g*AW +: AW]),
      .act_npc  (in_act_npc[g*AW +: AW]),
      .offset   (in_offset[g*OW +: OW]),
      .target   (tgt_vec[g*AW +: AW]),
      .mis      (mis_vec[g]),
      .taken    (taken_vec[g])
    );
  end

  erc_pick_oldest #(.SLOTS(SLOTS)) u_pick (
    .mis      (mis_vec),
    .first_oh (first_oh),
    .any      (any_mis)
  );

  // one-hot OR mux selecting the winning slot's fields
  always_comb begin
    sel_tgt   = '0;
    sel_seq   = '0;
    sel_taken = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      sel_tgt   = sel_tgt   | ({AW{first_oh[i]}} & tgt_vec[i*AW +: AW]);
      sel_seq   = sel_seq   | ({SW{first_oh[i]}} & in_seq[i*SW +: SW]);
      sel_taken = sel_taken | (first_oh[i] & taken_vec[i]);
    end
  end

  erc_kill_gen #(.SLOTS(SLOTS), .SW(SW)) u_kill (
    .valid    (in_valid),
    .seq      (in_seq),
    .done_seq (sel_seq),
    .any      (any_mis),
    .first_oh (first_oh),
    .kill     (kill_c),
    .fwd      (fwd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid   <= '0;
      fwd_ready   <= '0;
      kill_mask   <= '0;
      rd_valid    <= 1'b0;
      rd_squash   <= 1'b0;
      rd_mispred  <= 1'b0;
      rd_taken    <= 1'b0;
      rd_npc      <= '0;
      rd_nnpc     <= '0;
      rd_done_seq <= '0;
    end else begin
      fwd_valid  <= fwd_c;
      fwd_ready  <= fwd_c & in_no_src;
      kill_mask  <= kill_c;
      rd_valid   <= any_mis;
      rd_squash  <= any_mis;
      rd_mispred <= any_mis;
      if (any_mis) begin
        rd_taken    <= sel_taken;
        rd_npc      <= sel_tgt;
        rd_nnpc     <= sel_tgt + STEP;
        rd_done_seq <= sel_seq;
      end else begin
        rd_taken    <= 1'b0;
        rd_npc      <= '0;
        rd_nnpc     <= '0;
        rd_done_seq <= '0;
      end
    end
  end

  a_r3_nnpc_follows: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_nnpc == rd_npc + STEP));

  a_r3_flags_set: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_squash && rd_mispred));

  a_r5_no_kill_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (kill_mask == '0));

  a_r6_fwd_kill_disjoint: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid & kill_mask) == '0);

  a_r10_fwd_from_valid: assert property (@(posedge clk) disable iff (rst)
    ((fwd_valid | kill_mask) & ~$past(in_valid)) == '0);

  a_r7_ready_within_fwd: assert property (@(posedge clk) disable iff (rst)
    (fwd_ready & ~fwd_valid) == '0);
endmodule

// File: tb/test_early_redirect_check.sv
module test_early_redirect_check;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [W-1:0] fwd;
    logic [W-1:0] rdy;
    logic [W-1:0] kill;
    logic         rv;
    logic         taken;
    logic [31:0]  npc;
    logic [31:0]  nnpc;
    logic [15:0]  done;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0]    in_valid = '0, in_direct = '0, in_uncond = '0, in_no_src = '0;
  logic [W*32-1:0] in_pc = '0, in_pred_npc = '0, in_act_npc = '0;
  logic [W*16-1:0] in_offset = '0, in_seq = '0;
  logic [W-1:0]    fwd_valid, fwd_ready, kill_mask;
  logic            rd_valid, rd_squash, rd_mispred, rd_taken;
  logic [31:0]     rd_npc, rd_nnpc;
  logic [15:0]     rd_done_seq;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  string tags[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  early_redirect_check i_early_redirect_check (
    .clk, .rst, .in_valid, .in_pc, .in_pred_npc, .in_act_npc, .in_direct,
    .in_uncond, .in_offset, .in_seq, .in_no_src, .fwd_valid, .fwd_ready,
    .kill_mask, .rd_valid, .rd_squash, .rd_mispred, .rd_taken, .rd_npc,
    .rd_nnpc, .rd_done_seq
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    int first = -1;
    e = '0;
    for (int i = 0; i < W; i++) begin
      logic [31:0] pc, t;
      pc = in_pc[i*32 +: 32];
      t  = pc + {{16{in_offset[i*16+15]}}, in_offset[i*16 +: 16]};
      if (first < 0 && in_valid[i] && in_direct[i] && in_uncond[i] && t != in_pred_npc[i*32 +: 32]) begin
        first   = i;
        e.rv    = 1;
        e.npc   = t;
        e.nnpc  = t + 4;
        e.done  = in_seq[i*16 +: 16];
        e.taken = in_act_npc[i*32 +: 32] != pc + 4;
      end
    end
    for (int i = 0; i < W; i++) begin
      e.kill[i] = e.rv && in_valid[i] && (in_seq[i*16 +: 16] > e.done);
      e.fwd[i]  = in_valid[i] && !e.kill[i] && (first < 0 || i <= first);
      e.rdy[i]  = e.fwd[i] && in_no_src[i];
    end
    return e;
  endfunction

  task automatic set_slot(input int i, input bit v, input bit d, input bit u,
                          input logic [31:0] pc, input logic [15:0] off,
                          input logic [31:0] pred, input logic [31:0] act,
                          input logic [15:0] seq, input bit ns);
    in_valid[i] = v; in_direct[i] = d; in_uncond[i] = u; in_no_src[i] = ns;
    in_pc[i*32 +: 32] = pc; in_offset[i*16 +: 16] = off;
    in_pred_npc[i*32 +: 32] = pred; in_act_npc[i*32 +: 32] = act;
    in_seq[i*16 +: 16] = seq;
  endtask

  // plain group: sequential, non-branch, seq base..base+3
  task automatic plain(input logic [31:0] base_pc, input logic [15:0] base_seq);
    for (int i = 0; i < W; i++)
      set_slot(i, 1, 0, 0, base_pc + 4*i, 16'h0, base_pc + 4*i + 4, base_pc + 4*i + 4, base_seq + 16'(i), i[0]);
  endtask

  // driver: called at negedge after inputs are set
  task automatic push(input string tag);
    q.push_back(model());
    tags.push_back(tag);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tags.pop_front();
        chk(rd_valid == e.rv, {"R2 R1 R10 rd_valid ", t}, 64'(rd_valid), 64'(e.rv));
        chk(rd_squash == e.rv && rd_mispred == e.rv, {"R3 flags ", t}, {rd_squash, rd_mispred}, {e.rv, e.rv});
        chk(kill_mask == e.kill, {"R5 kill ", t}, 64'(kill_mask), 64'(e.kill));
        chk(fwd_valid == e.fwd, {"R6 fwd ", t}, 64'(fwd_valid), 64'(e.fwd));
        chk(fwd_ready == e.rdy, {"R7 ready ", t}, 64'(fwd_ready), 64'(e.rdy));
        if (e.rv) begin
          chk(rd_npc == e.npc && rd_nnpc == e.nnpc, {"R3 R8 npc ", t}, {rd_npc, rd_nnpc}, {e.npc, e.nnpc});
          chk(rd_done_seq == e.done, {"R3 R8 done_seq ", t}, 64'(rd_done_seq), 64'(e.done));
          chk(rd_taken == e.taken, {"R4 taken ", t}, 64'(rd_taken), 64'(e.taken));
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R9: reset clears outputs
    chk({fwd_valid, fwd_ready, kill_mask, rd_valid, rd_squash, rd_mispred, rd_taken} == '0,
        "R9 reset outputs", 64'({fwd_valid, kill_mask, rd_valid}), 64'h0);
    chk(rd_npc == 0 && rd_done_seq == 0, "R9 reset fields", {rd_npc, 16'h0, rd_done_seq}, 64'h0);
    rst = 0;

    plain(32'h1000, 16'd10);                       push("no branch");
    plain(32'h1000, 16'd20);
    set_slot(1, 1, 1, 1, 32'h1004, 16'h0040, 32'h1044, 32'h1044, 16'd21, 0);
    push("R2 correct prediction");
    plain(32'h2000, 16'd30);
    set_slot(1, 1, 1, 1, 32'h2004, 16'h0100, 32'h2008, 32'h2104, 16'd31, 1);
    push("R3 R4 mispredict slot1 taken");
    // R9: redirect lasts one cycle
    in_valid = '0;                                 push("R9 pulse end");
    plain(32'h3000, 16'd40);
    set_slot(2, 1, 1, 1, 32'h3008, 16'h0020, 32'h3010, 32'h300C, 16'd42, 0);
    push("R4 not taken");
    plain(32'h4000, 16'd50);
    set_slot(1, 1, 1, 1, 32'h4004, 16'h0010, 32'h4008, 32'h4014, 16'd51, 0);
    set_slot(3, 1, 1, 1, 32'h400C, 16'h0080, 32'h4010, 32'h408C, 16'd53, 0);
    push("R8 two mispredicts");
    plain(32'h5000, 16'd60);
    set_slot(0, 1, 1, 0, 32'h5000, 16'h0200, 32'h5004, 32'h5004, 16'd60, 0);
    set_slot(1, 1, 0, 1, 32'h5004, 16'h0200, 32'h5008, 32'h5008, 16'd61, 0);
    push("R1 single flag ignored");
    plain(32'h6000, 16'd70);
    set_slot(1, 0, 1, 1, 32'h6004, 16'h0300, 32'h6008, 32'h6008, 16'd71, 1);
    push("R10 invalid mispredict");
    plain(32'h7000, 16'd80);
    set_slot(2, 1, 1, 1, 32'h7008, 16'hFFF0, 32'h700C, 32'h6FF8, 16'd82, 1);
    push("R2 negative offset");
    plain(32'h8000, 16'd90);
    set_slot(0, 1, 1, 1, 32'h8000, 16'h0044, 32'h8004, 32'h8044, 16'd95, 1);
    set_slot(2, 1, 0, 0, 32'h8008, 16'h0, 32'h800C, 32'h800C, 16'd93, 1);
    push("R5 R6 seq out of order");
    in_no_src = 4'b1111; plain(32'h9000, 16'd100); in_no_src = 4'b1111;
    for (int i = 0; i < W; i++) in_no_src[i] = 1;
    push("R7 no-source");

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < W; i++) begin
        logic [31:0] pc;
        logic [15:0] off;
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        pc  = {lfsr[31:8], 8'h0} & 32'hFFFF_FFFC;
        off = {{6{lfsr[3]}}, lfsr[13:4]} & 16'hFFFC;
        set_slot(i, lfsr[0] | lfsr[1], lfsr[2], lfsr[5],
                 pc, off, lfsr[6] ? pc + {{16{off[15]}}, off} : pc + 4,
                 lfsr[7] ? pc + 4 : pc + 8, 16'(n*4) + 16'(lfsr[17:16]) + 16'(i), lfsr[9]);
      end
      push("R2 R5 R6 random");
    end
    in_valid = '0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule